// File: doc/BRIEF.md
# USB Device Event Interrupt Collector

This block gathers the event strobes of a USB device controller into a two-byte interrupt status register and drives an active-low interrupt line toward the local microcontroller. Each transaction event on one of the six endpoint indices latches its own bit. Bus reset, a change of suspend state and the end of a DMA transfer each latch a further bit. The bits do not all clear the same way. An endpoint bit is cleared only by the status read aimed at that endpoint. The three device-level bits are cleared by a read of the register itself.

The block also watches for suspend. A 1 ms tick advances a counter of consecutive frames that passed without a start-of-frame (SOF) packet. When the counter reaches its limit the device enters suspend, and the next SOF brings it back out. Both transitions set the suspend-change bit.

Two configuration bits choose what drives the interrupt line: the latched bits alone, the latched bits or a received SOF, or SOF alone. A bit has no way to remember an SOF, so an SOF drives the line low with a pulse of fixed length.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset both register bytes read 0x00, `int_n_o` is high and `suspended_o` is low.
- R2: A qualified event on endpoint index i sets bit i of byte 1 (`irq_lo_o[i]`, i = 0..5) one clock later. The bit stays set until `ep_stat_rd_i[i]` is pulsed. A register read or a status read of another endpoint leaves it set.
- R3: `busrst_i` sets `irq_lo_o[6]` and `dma_eot_i` sets `irq_hi_o[0]`. The suspend-change bit is `irq_lo_o[7]`. All three clear on a `reg_rd_i` pulse. `irq_hi_o[7:1]` always reads 0.
- R4: When an event and the clear of its own bit arrive in the same cycle, the bit is set after that edge.
- R5: An endpoint event flagged by `ep_nak_err_i` sets its bit only while `cfg_nak_irq_i` is 1. An event without that flag always sets its bit.
- R6: `cfg_ie_a_i` and `cfg_ie_b_i` gate the events of endpoint indices 4 and 5. While the enable is 0 the event leaves its bit clear.
- R7: After `MISS_LIMIT` (default 3) `ms_tick_i` pulses with no `sof_i` between them, `suspended_o` rises and `irq_lo_o[7]` sets at the same edge. Any SOF restarts the count.
- R8: An `sof_i` pulse while suspended drops `suspended_o` and sets `irq_lo_o[7]` at the same edge.
- R9: With `cfg_sof_only_i`=0 and `cfg_pin_sof_i`=0, `int_n_o` is low exactly while any bit of either byte is set. SOF has no effect on the line.
- R10: With `cfg_sof_only_i`=0 and `cfg_pin_sof_i`=1, `int_n_o` is low while any bit is set. It is also low for `SOF_PULSE` (default 4) cycles starting the clock after an `sof_i` pulse.
- R11: With `cfg_sof_only_i`=1, `int_n_o` ignores the register bits and the value of `cfg_pin_sof_i`. It is low only during the `SOF_PULSE`-cycle window after an SOF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ep_evt_i | input | EP_COUNT | Transaction event strobe per endpoint index |
| ep_nak_err_i | input | EP_COUNT | Marks the event as a NAK or an error |
| ep_stat_rd_i | input | EP_COUNT | Last-transaction-status read strobe per endpoint index |
| busrst_i | input | 1 | Bus reset event strobe |
| dma_eot_i | input | 1 | DMA end-of-transfer strobe |
| sof_i | input | 1 | SOF packet received strobe |
| ms_tick_i | input | 1 | One-millisecond frame tick |
| reg_rd_i | input | 1 | Interrupt register read strobe |
| cfg_nak_irq_i | input | 1 | 1: NAK/error events raise endpoint bits |
| cfg_sof_only_i | input | 1 | Pin is driven by SOF only |
| cfg_pin_sof_i | input | 1 | Pin is driven by register bits or SOF |
| cfg_ie_a_i | input | 1 | Event enable for endpoint index 4 |
| cfg_ie_b_i | input | 1 | Event enable for endpoint index 5 |
| irq_lo_o | output | 8 | Register byte 1 |
| irq_hi_o | output | 8 | Register byte 2 |
| suspended_o | output | 1 | Device is in suspend |
| int_n_o | output | 1 | Interrupt line, active low |

## Verification
The pin-mode properties compare `int_n_o` with the configuration bits seen in the same cycle. They therefore assume that the mode bits do not change while an SOF pulse is under way. The stimulus changes the configuration only after any pulse has expired and all flags are clear. The checker also assumes that `sof_i` and `ms_tick_i` never arrive in the same cycle, because the suspend count gives no defined order between them. The stimulus keeps these two strobes in separate cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      PIN_FLAGS     = 2'd0,
      PIN_FLAGS_SOF = 2'd1,
      PIN_SOF_ONLY  = 2'd2
   } pin_mode_e;

   localparam int unsigned EP_SLOTS    = 6;
   localparam int unsigned BIT_BUSRST  = 6;
   localparam int unsigned BIT_SUSPCHG = 7;
   localparam int unsigned BIT_DMAEOT  = 0;

   function automatic pin_mode_e decode_pin_mode(input logic sof_only, input logic pin_sof);
      if (sof_only)     return PIN_SOF_ONLY;
      else if (pin_sof) return PIN_FLAGS_SOF;
      else              return PIN_FLAGS;
   endfunction
endpackage

// File: rtl/irq_sticky.sv
module irq_sticky #(
   parameter int unsigned W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_r;

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_r[i] <= 1'b0;
            else        q_r[i] <= set_i[i] | (q_r[i] & ~clr_i);
         end
      end
   endgenerate

   assign q_o = q_r;
endmodule

// File: rtl/irq_ep_flags.sv
module irq_ep_flags #(
   parameter int unsigned EP_COUNT = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [EP_COUNT-1:0] evt_i,
   input  logic [EP_COUNT-1:0] nak_err_i,
   input  logic [EP_COUNT-1:0] ie_i,
   input  logic [EP_COUNT-1:0] stat_rd_i,
   input  logic                cfg_nak_i,
   output logic [EP_COUNT-1:0] flag_o
);
   logic [EP_COUNT-1:0] qual;
   logic [EP_COUNT-1:0] flag_r;

   generate
      for (genvar i = 0; i < EP_COUNT; i++) begin : g_ep
         assign qual[i] = evt_i[i] & ie_i[i] & (cfg_nak_i | ~nak_err_i[i]);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_r[i] <= 1'b0;
            else        flag_r[i] <= qual[i] | (flag_r[i] & ~stat_rd_i[i]);
         end
      end
   endgenerate

   assign flag_o = flag_r;
endmodule

// File: rtl/irq_sof_watch.sv
module irq_sof_watch #(
   parameter int unsigned MISS_LIMIT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sof_i,
   input  logic tick_i,
   output logic suspended_o,
   output logic change_o
);
   localparam int unsigned CW = (MISS_LIMIT > 1) ? $clog2(MISS_LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(MISS_LIMIT - 1);

   logic [CW-1:0] miss_q;
   logic          susp_q;
   logic          enter_now, leave_now;

   assign enter_now = tick_i & ~sof_i & ~susp_q & (miss_q == LAST);
   assign leave_now = sof_i & susp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_q <= '0;
         susp_q <= 1'b0;
      end else begin
         if (sof_i)          miss_q <= '0;
         else if (enter_now) miss_q <= '0;
         else if (tick_i && !susp_q) miss_q <= miss_q + 1'b1;

         if (enter_now)      susp_q <= 1'b1;
         else if (leave_now) susp_q <= 1'b0;
      end
   end

   assign suspended_o = susp_q;
   assign change_o    = enter_now | leave_now;
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
   import irq_pkg::*;
#(
   parameter int unsigned SOF_PULSE = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sof_i,
   input  logic      flag_any_i,
   input  pin_mode_e mode_i,
   output logic      int_n_o
);
   localparam int unsigned PW = $clog2(SOF_PULSE + 1);
   localparam logic [PW-1:0] LOAD = PW'(SOF_PULSE);

   logic [PW-1:0] pulse_q;
   logic          sof_win;
   logic          req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pulse_q <= '0;
      else if (sof_i)              pulse_q <= LOAD;
      else if (pulse_q != '0)      pulse_q <= pulse_q - 1'b1;
   end

   assign sof_win = (pulse_q != '0);

   always_comb begin
      unique case (mode_i)
         PIN_FLAGS:     req = flag_any_i;
         PIN_FLAGS_SOF: req = flag_any_i | sof_win;
         PIN_SOF_ONLY:  req = sof_win;
         default:       req = flag_any_i;
      endcase
   end

   assign int_n_o = ~req;
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
   import irq_pkg::*;
#(
   parameter int unsigned EP_COUNT   = 6,
   parameter int unsigned GATE_A     = 4,
   parameter int unsigned GATE_B     = 5,
   parameter int unsigned MISS_LIMIT = 3,
   parameter int unsigned SOF_PULSE  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [EP_COUNT-1:0] ep_evt_i,
   input  logic [EP_COUNT-1:0] ep_nak_err_i,
   input  logic [EP_COUNT-1:0] ep_stat_rd_i,
   input  logic                busrst_i,
   input  logic                dma_eot_i,
   input  logic                sof_i,
   input  logic                ms_tick_i,
   input  logic                reg_rd_i,
   input  logic                cfg_nak_irq_i,
   input  logic                cfg_sof_only_i,
   input  logic                cfg_pin_sof_i,
   input  logic                cfg_ie_a_i,
   input  logic                cfg_ie_b_i,
   output logic [7:0]          irq_lo_o,
   output logic [7:0]          irq_hi_o,
   output logic                suspended_o,
   output logic                int_n_o
);
   generate
      if (EP_COUNT < 1 || EP_COUNT > EP_SLOTS) begin : g_bad_count
         $error("EP_COUNT must lie in 1..6");
      end
      if (MISS_LIMIT < 1) begin : g_bad_miss
         $error("MISS_LIMIT must be at least 1");
      end
      if (SOF_PULSE < 1) begin : g_bad_pulse
         $error("SOF_PULSE must be at least 1");
      end
   endgenerate

   logic [EP_COUNT-1:0] ep_ie;
   logic [EP_COUNT-1:0] ep_flag;
   logic [EP_SLOTS-1:0] ep_slot;
   logic                susp_change;
   logic [2:0]          dev_set, dev_flag;
   logic                flag_any;

   generate
      for (genvar i = 0; i < EP_COUNT; i++) begin : g_ie
         if (i == GATE_A)      begin : g_a
            assign ep_ie[i] = cfg_ie_a_i;
         end else if (i == GATE_B) begin : g_b
            assign ep_ie[i] = cfg_ie_b_i;
         end else begin : g_on
            assign ep_ie[i] = 1'b1;
         end
      end
      for (genvar i = 0; i < EP_SLOTS; i++) begin : g_slot
         if (i < EP_COUNT) begin : g_used
            assign ep_slot[i] = ep_flag[i];
         end else begin : g_pad
            assign ep_slot[i] = 1'b0;
         end
      end
   endgenerate

   irq_ep_flags #(.EP_COUNT(EP_COUNT)) u_ep (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (ep_evt_i),
      .nak_err_i (ep_nak_err_i),
      .ie_i      (ep_ie),
      .stat_rd_i (ep_stat_rd_i),
      .cfg_nak_i (cfg_nak_irq_i),
      .flag_o    (ep_flag)
   );

   irq_sof_watch #(.MISS_LIMIT(MISS_LIMIT)) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .sof_i       (sof_i),
      .tick_i      (ms_tick_i),
      .suspended_o (suspended_o),
      .change_o    (susp_change)
   );

   assign dev_set = {dma_eot_i, susp_change, busrst_i};

   irq_sticky #(.W(3)) u_dev (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (dev_set),
      .clr_i (reg_rd_i),
      .q_o   (dev_flag)
   );

   always_comb begin
      irq_lo_o              = '0;
      irq_lo_o[EP_SLOTS-1:0] = ep_slot;
      irq_lo_o[BIT_BUSRST]  = dev_flag[0];
      irq_lo_o[BIT_SUSPCHG] = dev_flag[1];
      irq_hi_o              = '0;
      irq_hi_o[BIT_DMAEOT]  = dev_flag[2];
   end

   assign flag_any = (|ep_slot) | (|dev_flag);

   irq_pin_drive #(.SOF_PULSE(SOF_PULSE)) u_pin (
      .clk        (clk),
      .rst_n      (rst_n),
      .sof_i      (sof_i),
      .flag_any_i (flag_any),
      .mode_i     (decode_pin_mode(cfg_sof_only_i, cfg_pin_sof_i)),
      .int_n_o    (int_n_o)
   );
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
   parameter int unsigned EP_COUNT = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic [EP_COUNT-1:0] ep_stat_rd_i,
   input logic                busrst_i,
   input logic                dma_eot_i,
   input logic                sof_i,
   input logic                reg_rd_i,
   input logic                cfg_sof_only_i,
   input logic                cfg_pin_sof_i,
   input logic [7:0]          irq_lo_o,
   input logic [7:0]          irq_hi_o,
   input logic                suspended_o,
   input logic                int_n_o
);
   generate
      for (genvar i = 0; i < EP_COUNT; i++) begin : g_hold
         // R2
         ep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_lo_o[i] && !ep_stat_rd_i[i] |=> irq_lo_o[i]);
      end
   endgenerate

   // R3
   busrst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_i && !busrst_i |=> !irq_lo_o[6]);

   // R3
   eot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_i && !dma_eot_i |=> !irq_hi_o[0]);

   // R7
   susp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(suspended_o) |-> irq_lo_o[7]);

   // R9
   quiet_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sof_only_i && !cfg_pin_sof_i && irq_lo_o == 8'h00 && irq_hi_o == 8'h00 |-> int_n_o);

   // R10
   flag_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_sof_only_i && (irq_lo_o != 8'h00) |-> !int_n_o);

   // R11
   sof_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sof_i) && cfg_sof_only_i |-> !int_n_o);
endmodule

bind evt_irq_hub evt_irq_hub_chk #(.EP_COUNT(EP_COUNT)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ep_stat_rd_i   (ep_stat_rd_i),
   .busrst_i       (busrst_i),
   .dma_eot_i      (dma_eot_i),
   .sof_i          (sof_i),
   .reg_rd_i       (reg_rd_i),
   .cfg_sof_only_i (cfg_sof_only_i),
   .cfg_pin_sof_i  (cfg_pin_sof_i),
   .irq_lo_o       (irq_lo_o),
   .irq_hi_o       (irq_hi_o),
   .suspended_o    (suspended_o),
   .int_n_o        (int_n_o)
);

// File: tb/evt_irq_hub_tb.sv
module evt_irq_hub_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NEP = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NEP-1:0] ep_evt = '0, ep_nak = '0, ep_rd = '0;
   logic busrst = 0, eot = 0, sof = 0, tick = 0, rrd = 0;
   logic c_nak = 1, c_sof_only = 0, c_pin_sof = 0, c_ie4 = 1, c_ie5 = 1;
   logic [7:0] lo, hi;
   logic susp, intn;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   string tag_q[$];
   logic [17:0] val_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   evt_irq_hub u_dut (
      .clk(clk), .rst_n(rst_n),
      .ep_evt_i(ep_evt), .ep_nak_err_i(ep_nak), .ep_stat_rd_i(ep_rd),
      .busrst_i(busrst), .dma_eot_i(eot), .sof_i(sof), .ms_tick_i(tick),
      .reg_rd_i(rrd), .cfg_nak_irq_i(c_nak), .cfg_sof_only_i(c_sof_only),
      .cfg_pin_sof_i(c_pin_sof), .cfg_ie_a_i(c_ie4), .cfg_ie_b_i(c_ie5),
      .irq_lo_o(lo), .irq_hi_o(hi), .suspended_o(susp), .int_n_o(intn)
   );

   // expected item: {lo, hi, int_n, suspended}
   task automatic expect_now(input string tag, input logic [7:0] elo, input logic [7:0] ehi,
                             input logic eint, input logic esusp);
      tag_q.push_back(tag);
      val_q.push_back({elo, ehi, eint, esusp});
   endtask

   // monitor: compares pending expectations just after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         while (val_q.size() > 0) begin
            string t;
            logic [17:0] e, a;
            t = tag_q.pop_front();
            e = val_q.pop_front();
            a = {lo, hi, intn, susp};
            n_chk++;
            if (a !== e) begin
               n_bad++;
               $display("FAIL %s: lo/hi/int_n/susp actual %h/%h/%b/%b expected %h/%h/%b/%b",
                        t, a[17:10], a[9:2], a[1], a[0], e[17:10], e[9:2], e[1], e[0]);
            end
         end
      end
   end

   // one clock with the given strobes held, then released at the falling edge
   task automatic strobe(input logic [NEP-1:0] ev, input logic [NEP-1:0] nk,
                         input logic [NEP-1:0] rd, input logic br, input logic eo,
                         input logic sf, input logic tk, input logic rr);
      ep_evt = ev; ep_nak = nk; ep_rd = rd;
      busrst = br; eot = eo; sof = sf; tick = tk; rrd = rr;
      @(negedge clk);
      ep_evt = '0; ep_nak = '0; ep_rd = '0;
      busrst = 0; eot = 0; sof = 0; tick = 0; rrd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      idle(2);
      rst_n = 1'b1;
      expect_now("R1", 8'h00, 8'h00, 1'b1, 1'b0);
      idle(1);

      // R2 endpoint bit set and held
      strobe(6'b000100, 0, 0, 0, 0, 0, 0, 0);
      expect_now("R2", 8'h04, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 0, 0, 0, 0, 0, 1);
      expect_now("R2", 8'h04, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 6'b001000, 0, 0, 0, 0, 0);
      expect_now("R2", 8'h04, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 6'b000100, 0, 0, 0, 0, 0);
      expect_now("R9", 8'h00, 8'h00, 1'b1, 1'b0);

      // R3 device bits, clear on read
      strobe(0, 0, 0, 1, 0, 0, 0, 0);
      expect_now("R3", 8'h40, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 0, 0, 1, 0, 0, 0);
      expect_now("R3", 8'h40, 8'h01, 1'b0, 1'b0);
      strobe(0, 0, 0, 0, 0, 0, 0, 1);
      expect_now("R3", 8'h00, 8'h00, 1'b1, 1'b0);

      // R4 set wins over same-cycle clear
      strobe(6'b000010, 0, 6'b000010, 0, 0, 0, 0, 0);
      expect_now("R4", 8'h02, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 6'b000010, 0, 0, 0, 0, 0);
      strobe(0, 0, 0, 1, 1, 0, 0, 1);
      expect_now("R4", 8'h40, 8'h01, 1'b0, 1'b0);
      strobe(0, 0, 0, 0, 0, 0, 0, 1);
      expect_now("R4", 8'h00, 8'h00, 1'b1, 1'b0);

      // R5 NAK/error qualifier
      c_nak = 0;
      strobe(6'b000001, 6'b000001, 0, 0, 0, 0, 0, 0);
      expect_now("R5", 8'h00, 8'h00, 1'b1, 1'b0);
      strobe(6'b000001, 0, 0, 0, 0, 0, 0, 0);
      expect_now("R5", 8'h01, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 6'b000001, 0, 0, 0, 0, 0);
      c_nak = 1;
      strobe(6'b000001, 6'b000001, 0, 0, 0, 0, 0, 0);
      expect_now("R5", 8'h01, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 6'b000001, 0, 0, 0, 0, 0);

      // R6 enables for indices 4 and 5
      c_ie4 = 0; c_ie5 = 0;
      strobe(6'b110000, 0, 0, 0, 0, 0, 0, 0);
      expect_now("R6", 8'h00, 8'h00, 1'b1, 1'b0);
      c_ie4 = 1;
      strobe(6'b110000, 0, 0, 0, 0, 0, 0, 0);
      expect_now("R6", 8'h10, 8'h00, 1'b0, 1'b0);
      c_ie5 = 1;
      strobe(6'b100000, 0, 0, 0, 0, 0, 0, 0);
      expect_now("R6", 8'h30, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 6'b110000, 0, 0, 0, 0, 0);
      expect_now("R6", 8'h00, 8'h00, 1'b1, 1'b0);

      // R9 SOF does not move the pin in mode 0
      strobe(0, 0, 0, 0, 0, 1, 0, 0);
      expect_now("R9", 8'h00, 8'h00, 1'b1, 1'b0);
      idle(5);

      // R10 SOF pulse of 4 cycles in mode 1
      c_pin_sof = 1;
      idle(1);
      strobe(0, 0, 0, 0, 0, 1, 0, 0);
      expect_now("R10", 8'h00, 8'h00, 1'b0, 1'b0);
      idle(3);
      expect_now("R10", 8'h00, 8'h00, 1'b0, 1'b0);
      idle(1);
      expect_now("R10", 8'h00, 8'h00, 1'b1, 1'b0);
      c_pin_sof = 0;

      // R11 SOF only: flags ignored
      c_sof_only = 1; c_pin_sof = 1;
      strobe(6'b000010, 0, 0, 0, 0, 0, 0, 0);
      expect_now("R11", 8'h02, 8'h00, 1'b1, 1'b0);
      strobe(0, 0, 0, 0, 0, 1, 0, 0);
      expect_now("R11", 8'h02, 8'h00, 1'b0, 1'b0);
      idle(3);
      expect_now("R11", 8'h02, 8'h00, 1'b0, 1'b0);
      idle(1);
      expect_now("R11", 8'h02, 8'h00, 1'b1, 1'b0);
      strobe(0, 0, 6'b000010, 0, 0, 0, 0, 0);
      c_sof_only = 0; c_pin_sof = 0;
      idle(1);

      // R7 suspend after three silent ticks, SOF restarts count
      strobe(0, 0, 0, 0, 0, 0, 1, 0);
      strobe(0, 0, 0, 0, 0, 0, 1, 0);
      strobe(0, 0, 0, 0, 0, 1, 0, 0);
      strobe(0, 0, 0, 0, 0, 0, 1, 0);
      strobe(0, 0, 0, 0, 0, 0, 1, 0);
      expect_now("R7", 8'h00, 8'h00, 1'b1, 1'b0);
      strobe(0, 0, 0, 0, 0, 0, 1, 0);
      expect_now("R7", 8'h80, 8'h00, 1'b0, 1'b1);
      strobe(0, 0, 0, 0, 0, 0, 1, 0);
      strobe(0, 0, 0, 0, 0, 0, 0, 1);
      expect_now("R7", 8'h00, 8'h00, 1'b1, 1'b1);

      // R8 resume on SOF
      strobe(0, 0, 0, 0, 0, 1, 0, 0);
      expect_now("R8", 8'h80, 8'h00, 1'b0, 1'b0);
      strobe(0, 0, 0, 0, 0, 0, 0, 1);
      expect_now("R8", 8'h00, 8'h00, 1'b1, 1'b0);
      idle(2);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule